// File: doc/BRIEF.md
# Wall-Following Antenna Robot Steering Controller

This block steers a small robot through a maze by keeping one side against a wall. Two touch antennas, left and right, are its only inputs. Three motion commands come out: turn left, turn right and drive forward. Internally it is a Moore state machine with four states, held in a two-bit register.

The four states are lost, rotate counterclockwise, wall tracking and wall re-acquire. The wall-tracking state also does the job of a separate corner state found in a five-state formulation. The two had identical outputs and identical successors, so merging them loses no behaviour and saves one state bit.

The next state can be built two ways, chosen by a parameter. One is a minimal sum-of-products gate network. The other is a 16-entry lookup table indexed by state and antennas. Both ways give the same machine.

Top module: `ant_steer`

## Requirements
- R1: While `rst_ni` is low, the state is lost (`state_o` = 2'b00) and the outputs are forward only: `fwd_o`=1, `turn_l_o`=0, `turn_r_o`=0.
- R2: In lost (00), with neither antenna touching, the next state is lost. With either antenna or both touching, the next state is rotate counterclockwise (01).
- R3: In rotate counterclockwise (01), with either antenna or both touching, the machine stays in 01. With neither touching, the next state is wall tracking (10).
- R4: In wall tracking (10), the next state depends only on the right antenna. Right=1 gives wall re-acquire (11). Right=0 gives 10. The left antenna has no effect.
- R5: In wall re-acquire (11), left=1 gives 01, and this takes priority over the right antenna. Otherwise right=1 gives 11. With neither touching, the next state is 10.
- R6: The outputs, as {turn_l, turn_r, fwd}, are fixed per state: lost 001, rotate counterclockwise 100, wall tracking 011, wall re-acquire 101. Turn left and turn right are never both 1.
- R7: The outputs depend only on the registered state. An antenna change between clock edges leaves the outputs unchanged until the next rising edge.
- R8: For any antenna sequence, the outputs match those of the unreduced five-state machine cycle for cycle. In that machine, a separate corner state (outputs 011) is entered from wall tracking on right=0 and held on right=0. On right=1 it leaves for wall re-acquire.
- R9: With `USE_ROM`=1, state and outputs are identical to `USE_ROM`=0 for every input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ant_l_i | input | 1 | Left antenna touching |
| ant_r_i | input | 1 | Right antenna touching |
| turn_l_o | output | 1 | Turn-left command |
| turn_r_o | output | 1 | Turn-right command |
| fwd_o | output | 1 | Drive-forward command |
| state_o | output | 2 | Registered state code |

## Verification
A wrong next-state term shows at the ports exactly one rising edge after the offending antenna pattern. Each state has a distinct output triple and `state_o` exposes the register, so the fault appears on the following sample. An error that only swaps wall tracking with the former corner state is the case output comparison cannot catch. For that reason every state is reached and hit with all four antenna patterns. A long pseudo-random sequence is then replayed against a five-state model, so that a wrong state is also caught through the divergence it causes in later cycles. Both next-state variants run side by side on the same inputs.

// File: rtl/ant_pkg.sv
package ant_pkg;
  typedef enum logic [1:0] {
    ST_LOST  = 2'b00,
    ST_RCCW  = 2'b01,
    ST_WALL  = 2'b10,
    ST_WALL2 = 2'b11
  } ant_state_e;

  typedef struct packed {
    logic turn_l;
    logic turn_r;
    logic fwd;
  } ant_drive_t;

  localparam int unsigned StateW = $bits(ant_state_e);
  localparam int unsigned IdxW   = StateW + 2;
  localparam int unsigned Rows   = 1 << IdxW;
endpackage

// File: rtl/ant_next_sop.sv
module ant_next_sop
  import ant_pkg::*;
(
  input  ant_state_e state_i,
  input  logic       ant_l_i,
  input  logic       ant_r_i,
  output ant_state_e next_o
);
  logic s1, s0, n1, n0;

  assign s1 = state_i[1];
  assign s0 = state_i[0];

  // minimal covers derived from the four-state transition table
  assign n1 = (s1 & ~s0) | (s1 & ~ant_l_i) | (~s1 & s0 & ~ant_l_i & ~ant_r_i);
  assign n0 = ant_r_i | (ant_l_i & ~s1) | (ant_l_i & s0);

  assign next_o = ant_state_e'({n1, n0});
endmodule

// File: rtl/ant_next_rom.sv
module ant_next_rom
  import ant_pkg::*;
(
  input  ant_state_e state_i,
  input  logic       ant_l_i,
  input  logic       ant_r_i,
  output ant_state_e next_o
);
  function automatic logic [StateW-1:0] row_val(logic [IdxW-1:0] idx);
    logic [StateW-1:0] s;
    logic l, r;
    s = idx[IdxW-1:2];
    l = idx[1];
    r = idx[0];
    case (s)
      2'b00:   row_val = (l | r) ? 2'b01 : 2'b00;
      2'b01:   row_val = (l | r) ? 2'b01 : 2'b10;
      2'b10:   row_val = r ? 2'b11 : 2'b10;
      default: row_val = l ? 2'b01 : (r ? 2'b11 : 2'b10);
    endcase
  endfunction

  function automatic logic [Rows*StateW-1:0] build_rom();
    logic [Rows*StateW-1:0] t;
    t = '0;
    for (int i = 0; i < Rows; i++) begin
      t[i*StateW +: StateW] = row_val(IdxW'(i));
    end
    return t;
  endfunction

  localparam logic [Rows*StateW-1:0] RomBits = build_rom();

  logic [IdxW-1:0] idx;
  assign idx    = {state_i, ant_l_i, ant_r_i};
  assign next_o = ant_state_e'(RomBits[idx*StateW +: StateW]);
endmodule

// File: rtl/ant_out_dec.sv
module ant_out_dec
  import ant_pkg::*;
(
  input  ant_state_e state_i,
  output ant_drive_t drive_o
);
  assign drive_o.turn_l = state_i[0];
  assign drive_o.turn_r = state_i[1] & ~state_i[0];
  assign drive_o.fwd    = state_i[1] | ~state_i[0];
endmodule

// File: rtl/ant_steer.sv
module ant_steer
  import ant_pkg::*;
#(
  parameter bit USE_ROM = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ant_l_i,
  input  logic              ant_r_i,
  output logic              turn_l_o,
  output logic              turn_r_o,
  output logic              fwd_o,
  output logic [StateW-1:0] state_o
);
  ant_state_e state_q, state_d;
  ant_drive_t drive;

  generate
    if (USE_ROM) begin : g_rom
      ant_next_rom u_next (
        .state_i(state_q), .ant_l_i(ant_l_i), .ant_r_i(ant_r_i), .next_o(state_d)
      );
    end else begin : g_sop
      ant_next_sop u_next (
        .state_i(state_q), .ant_l_i(ant_l_i), .ant_r_i(ant_r_i), .next_o(state_d)
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_LOST;
    else         state_q <= state_d;
  end

  ant_out_dec u_dec (.state_i(state_q), .drive_o(drive));

  assign turn_l_o = drive.turn_l;
  assign turn_r_o = drive.turn_r;
  assign fwd_o    = drive.fwd;
  assign state_o  = state_q;

  AST_LOST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LOST && !ant_l_i && !ant_r_i |=> state_q == ST_LOST); // R2
  AST_LOST_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LOST && (ant_l_i || ant_r_i) |=> state_q == ST_RCCW); // R2
  AST_RCCW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RCCW && (ant_l_i || ant_r_i) |=> state_q == ST_RCCW); // R3
  AST_RCCW_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RCCW && !ant_l_i && !ant_r_i |=> state_q == ST_WALL); // R3
  AST_WALL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WALL |=> state_q == ($past(ant_r_i) ? ST_WALL2 : ST_WALL)); // R4
  AST_WALL2_LPRI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WALL2 && ant_l_i |=> state_q == ST_RCCW); // R5
  AST_WALL2_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WALL2 && !ant_l_i && !ant_r_i |=> state_q == ST_WALL); // R5
  AST_ONE_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(turn_l_o && turn_r_o)); // R6
  AST_MOORE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(state_o) |-> $stable({turn_l_o, turn_r_o, fwd_o})); // R7
endmodule

// File: tb/sim_ant_steer.sv
module sim_ant_steer;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  localparam int M_LOST = 0, M_RCCW = 1, M_WALL = 2, M_CORNER = 3, M_WALL2 = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ant_l = 1'b0, ant_r = 1'b0;
  logic tl0, tr0, f0, tl1, tr1, f1;
  logic [1:0] st0, st1;
  int checks = 0, errors = 0, model = M_LOST;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ant_steer #(.USE_ROM(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ant_l_i(ant_l), .ant_r_i(ant_r),
    .turn_l_o(tl0), .turn_r_o(tr0), .fwd_o(f0), .state_o(st0)
  );
  ant_steer #(.USE_ROM(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .ant_l_i(ant_l), .ant_r_i(ant_r),
    .turn_l_o(tl1), .turn_r_o(tr1), .fwd_o(f1), .state_o(st1)
  );

  // five-state reference machine, corner kept separate
  function automatic int m_next(int s, logic l, logic r);
    case (s)
      M_LOST:   return (l | r) ? M_RCCW : M_LOST;
      M_RCCW:   return (l | r) ? M_RCCW : M_WALL;
      M_WALL:   return r ? M_WALL2 : M_CORNER;
      M_CORNER: return r ? M_WALL2 : M_CORNER;
      default:  return l ? M_RCCW : (r ? M_WALL2 : M_WALL);
    endcase
  endfunction

  function automatic logic [2:0] m_out(int s);
    case (s)
      M_LOST:            return 3'b001;
      M_RCCW:            return 3'b100;
      M_WALL, M_CORNER:  return 3'b011;
      default:           return 3'b101;
    endcase
  endfunction

  function automatic logic [1:0] m_code(int s);
    case (s)
      M_LOST:            return 2'b00;
      M_RCCW:            return 2'b01;
      M_WALL, M_CORNER:  return 2'b10;
      default:           return 2'b11;
    endcase
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(int s);
    case (s)
      M_LOST:            return "R2";
      M_RCCW:            return "R3";
      M_WALL, M_CORNER:  return "R4";
      default:           return "R5";
    endcase
  endfunction

  // called at a falling edge; applies inputs across one rising edge
  task automatic cyc(logic l, logic r);
    string t;
    t = tag_of(model);
    ant_l = l;
    ant_r = r;
    @(posedge clk);
    model = m_next(model, l, r);
    @(negedge clk);
    check(t, {st0, tl0, tr0, f0}, {m_code(model), m_out(model)});
    check("R6", {2'b00, tl0, tr0, f0}, {2'b00, m_out(model)});
    check("R8", {2'b00, tl0, tr0, f0}, {2'b00, m_out(model)});
    check("R9", {st1, tl1, tr1, f1}, {st0, tl0, tr0, f0});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    ant_l = 1'b1;
    ant_r = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", {st0, tl0, tr0, f0}, 5'b00_001);
    check("R1", {st1, tl1, tr1, f1}, 5'b00_001);
    ant_l = 1'b0;
    ant_r = 1'b0;
    rst_ni = 1'b1;
    model = M_LOST;
  endtask

  task automatic goto(int target);
    case (target)
      M_RCCW: cyc(1'b1, 1'b0);
      M_WALL: begin cyc(1'b1, 1'b0); cyc(1'b0, 1'b0); end
      M_CORNER: begin cyc(1'b1, 1'b0); cyc(1'b0, 1'b0); cyc(1'b1, 1'b0); end
      M_WALL2: begin cyc(1'b1, 1'b0); cyc(1'b0, 1'b0); cyc(1'b0, 1'b1); end
      default: ;
    endcase
  endtask

  initial begin
    logic [15:0] lfsr;
    logic [4:0] held;
    lfsr = 16'hACE1;
    do_reset();

    // every reachable state against every antenna pattern
    for (int s = M_LOST; s <= M_WALL2; s++) begin
      for (int p = 0; p < 4; p++) begin
        do_reset();
        goto(s);
        cyc(p[1], p[0]);
      end
    end

    // R4: left antenna alone does not leave wall tracking
    do_reset();
    goto(M_WALL);
    cyc(1'b1, 1'b0);
    check("R4", {3'b000, st0}, 5'b00010);

    // R5: both antennas in re-acquire resolve to rotate counterclockwise
    do_reset();
    goto(M_WALL2);
    cyc(1'b1, 1'b1);
    check("R5", {3'b000, st0}, 5'b00001);

    // R7: input changes between edges do not move the outputs
    for (int s = M_LOST; s <= M_WALL2; s++) begin
      do_reset();
      goto(s);
      held = {st0, tl0, tr0, f0};
      for (int p = 0; p < 4; p++) begin
        ant_l = p[1];
        ant_r = p[0];
        #1;
        check("R7", {st0, tl0, tr0, f0}, held);
      end
      ant_l = 1'b0;
      ant_r = 1'b0;
      #1;
    end

    // R8, R9: long pseudo-random walk against the five-state model
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0], lfsr[7]);
      if (i == 2500) do_reset();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R8: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule